// File: doc/BRIEF.md
# Stream Receive Length Checker

This block is the receive half of a simple DMA channel, the half that moves data from a stream into memory. It accepts packets on a stream slave port that carries only data, valid, ready and last. Each accepted beat is forwarded to a write port whose address starts at a programmed base and steps by one word per beat. The block counts the bytes of the packet. When the packet ends, it compares that count against the transfer length that software programmed.

A packet that ends exactly on the programmed length completes cleanly. A packet that ends early is a length mismatch. So is a source that keeps last low until the programmed length has been consumed. On a mismatch the channel latches an error, halts, and stops accepting beats until software restarts it. Software drives the block through four word registers on a small write/read port.

Top module: `s2m_len_checker`

## Requirements
- R1: After reset, every status bit reads 0, `s_tready` is low, and both interrupt outputs are low.
- R2: A transfer starts when software writes a nonzero value to the length register (offset 3) while run (control offset 0, bit 0) is 1 and halted is 0. A length write of zero, or a length write while run is 0, is ignored. `s_tready` is high only while a transfer is active, and never while the channel is halted.
- R3: Each accepted beat (`s_tvalid` and `s_tready` high at a rising edge) gives `wr_en` high in that cycle, with `wr_data` equal to `s_tdata`. The `wr_addr` of beat n (counting from 0) is base (offset 2) plus 4·n.
- R4: Each accepted beat adds 4 bytes to the count. If a beat carries `s_tlast` and the count equals the length, the transfer ends with done-interrupt set (status bit 4) and no error. `s_tready` is low from the next cycle.
- R5: If a beat carries `s_tlast` while the count differs from the length, all of the following are set: error (status bit 1), halted (status bit 0), error-interrupt (status bit 5) and done-interrupt.
- R6: If the count reaches or passes the length on a beat without `s_tlast`, the result is the same as in R5. `s_tready` is low from the next cycle, so no further beat is accepted.
- R7: Halted and error survive a write of run=1 while run is already 1, and a halted channel ignores length writes. Both are cleared only by reset, or by writing run=0 and then run=1.
- R8: Writing 1 to status bit 4 or bit 5 clears that interrupt bit alone. Writing 0 has no effect. The `irq_done` and `irq_err` outputs follow status bits 4 and 5. Status bit 2 reads 1 while a transfer is active.
- R9: A length write during an active transfer is ignored, and the transfer is judged against the length it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 base, 3 length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| s_tdata | input | 32 | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tready | output | 1 | Stream ready |
| s_tlast | input | 1 | Stream end of packet |
| wr_en | output | 1 | Write-port strobe, one per accepted beat |
| wr_addr | output | 32 | Write-port byte address |
| wr_data | output | 32 | Write-port data |
| irq_done | output | 1 | Transfer-ended interrupt flag |
| irq_err | output | 1 | Length-mismatch interrupt flag |

## Verification
The bench sweeps programmed lengths that are whole words and lengths that are not. Each length is tried with last on every beat position and with last never asserted. This covers an early last, which a design that only looks at the counter would accept silently. It also covers a missing last, which a design without the length cut-off would leave hanging with ready stuck high. A length that is not a whole word catches a design that compares only for equality, because its counter would wrap instead of stopping. Directed steps check three more things: that a halted channel stays locked through a redundant run write, that each interrupt clears alone, and that a mid-transfer length write cannot move the end point.

// File: rtl/s2m_len_checker.sv
module s2m_len_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              irq_done,
  output logic              irq_err
);
  localparam int BYTES = DATA_W / 8;
  localparam int CNT_W = LEN_W + 1;

  logic              run, busy, halted, err, done_q, errq_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt;

  wire accept = s_tvalid & busy;
  wire [CNT_W-1:0] cnt_nx = cnt + CNT_W'(BYTES);
  wire hit   = cnt_nx == {1'b0, len_q};
  wire reach = cnt_nx >= {1'b0, len_q};
  wire fin   = accept & (s_tlast | reach);
  wire bad   = fin & ~(s_tlast & hit);

  wire wr_ctrl = reg_we & (reg_addr == 2'd0);
  wire wr_stat = reg_we & (reg_addr == 2'd1);
  wire wr_base = reg_we & (reg_addr == 2'd2);
  wire wr_len  = reg_we & (reg_addr == 2'd3);
  wire start   = wr_len & run & ~halted & ~busy & (|reg_wdata[LEN_W-1:0]);
  wire run_up  = wr_ctrl & reg_wdata[0] & ~run;

  assign s_tready = busy;
  assign wr_en    = accept;
  assign wr_addr  = addr_q;
  assign wr_data  = s_tdata;
  assign irq_done = done_q;
  assign irq_err  = errq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      busy   <= 1'b0;
      halted <= 1'b0;
      err    <= 1'b0;
      done_q <= 1'b0;
      errq_q <= 1'b0;
      base_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ctrl) run <= reg_wdata[0];
      if (wr_base) base_q <= reg_wdata[ADDR_W-1:0];
      if (start) begin
        len_q  <= reg_wdata[LEN_W-1:0];
        cnt    <= '0;
        addr_q <= base_q;
        busy   <= 1'b1;
      end
      if (accept) begin
        cnt    <= cnt_nx;
        addr_q <= addr_q + ADDR_W'(BYTES);
      end
      if (fin) busy <= 1'b0;
      if (wr_ctrl && !reg_wdata[0]) busy <= 1'b0;
      if (run_up) begin
        halted <= 1'b0;
        err    <= 1'b0;
      end
      if (bad) begin
        halted <= 1'b1;
        err    <= 1'b1;
      end
      if (wr_stat && reg_wdata[4]) done_q <= 1'b0;
      if (fin) done_q <= 1'b1;
      if (wr_stat && reg_wdata[5]) errq_q <= 1'b0;
      if (bad) errq_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'b0, run};
      2'd1:    reg_rdata = {26'b0, errq_q, done_q, 1'b0, busy, err, halted};
      2'd2:    reg_rdata = 32'(base_q);
      default: reg_rdata = 32'(len_q);
    endcase
  end
endmodule

module s2m_len_checker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_tready,
  input logic        wr_en,
  input logic [31:0] wr_addr,
  input logic        halted,
  input logic        err,
  input logic        irq_done,
  input logic        irq_err
);
  // R2
  halted_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !s_tready);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_addr == $past(wr_addr) + 32'd4);
  // R5
  err_sets_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> halted && irq_err && irq_done);
  // R6
  err_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !s_tready);
  // R4
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $past(wr_en));
  // R5
  err_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(wr_en));
endmodule

bind s2m_len_checker s2m_len_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .wr_en(wr_en),
  .wr_addr(wr_addr), .halted(halted), .err(err),
  .irq_done(irq_done), .irq_err(irq_err)
);

// File: tb/sim_s2m_len_checker.sv
module sim_s2m_len_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        irq_done, irq_err;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  s2m_len_checker u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_case(input int len, input int last_at, input int k);
    logic [31:0] base, st, exp_st;
    int got, exp_beats, wlen;
    bit e;
    reg_wr(2'd0, 32'd0);
    reg_wr(2'd0, 32'd1);
    reg_wr(2'd1, 32'h30);
    base = 32'h1000 + 32'(k) * 32'h40;
    reg_wr(2'd2, base);
    reg_wr(2'd3, 32'(len));
    got = 0;
    for (int i = 0; i < 8; i++) begin
      s_tvalid = 1'b1;
      s_tdata  = 32'hA000_0000 | (32'(k) << 8) | 32'(i);
      s_tlast  = (i + 1 == last_at);
      #1;
      if (!s_tready) break;
      // R3
      chk(wr_en && wr_addr == base + 32'(4 * i) && wr_data == s_tdata,
          "R3 write port", wr_addr, base + 32'(4 * i));
      got++;
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    @(negedge clk);
    wlen = (len + 3) / 4;
    exp_beats = (last_at > 0 && last_at < wlen) ? last_at : wlen;
    e = !(last_at > 0 && last_at * 4 == len);
    exp_st = {26'b0, e, 1'b1, 1'b0, 1'b0, e, e};
    // R6 (beats stop at the length) and R4/R5 (beats stop at last)
    chk(got == exp_beats, e ? "R6/R5 beat count" : "R4 beat count", 32'(got), 32'(exp_beats));
    reg_rd(2'd1, st);
    chk(st == exp_st, e ? "R5/R6 status" : "R4 status", st, exp_st);
    chk(irq_done == 1'b1 && irq_err == e, "R8 irq outputs", {30'b0, irq_err, irq_done}, {30'b0, e, 1'b1});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] st;
    int lens [8] = '{4, 8, 12, 16, 20, 24, 6, 10};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    reg_rd(2'd1, st);
    chk(st == 32'd0 && !s_tready && !irq_done && !irq_err, "R1 reset", st, 32'd0);

    // R2: run clear, length ignored
    reg_wr(2'd3, 32'd8);
    #1 chk(!s_tready, "R2 length ignored while stopped", {31'b0, s_tready}, 32'd0);
    reg_wr(2'd0, 32'd1);
    reg_wr(2'd3, 32'd0);
    #1 chk(!s_tready, "R2 zero length ignored", {31'b0, s_tready}, 32'd0);
    reg_wr(2'd3, 32'd8);
    #1 chk(s_tready, "R2 start", {31'b0, s_tready}, 32'd1);
    reg_rd(2'd1, st);
    chk(st[2] == 1'b1, "R8 active bit", st, 32'h4);

    // R9: a mid-transfer length write is ignored
    s_tvalid = 1'b1; s_tdata = 32'h1111_0000; s_tlast = 1'b0;
    @(negedge clk);
    s_tvalid = 1'b0;
    reg_wr(2'd3, 32'd4);
    s_tvalid = 1'b1; s_tdata = 32'h1111_0001; s_tlast = 1'b1;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    reg_rd(2'd1, st);
    chk(st == 32'h10, "R9 length held during transfer", st, 32'h10);

    for (int li = 0; li < 8; li++)
      for (int la = 0; la <= 8; la++)
        run_case(lens[li], la, li * 9 + la);

    // R7: force an error, then try to restart without a run cycle
    run_case(8, 1, 99);
    reg_wr(2'd0, 32'd1);
    reg_wr(2'd3, 32'd8);
    #1 chk(!s_tready, "R7 halted ignores start", {31'b0, s_tready}, 32'd0);
    reg_rd(2'd1, st);
    chk(st[1:0] == 2'b11, "R7 halted and error kept", st, 32'h33);
    // R8: clear each interrupt alone
    reg_wr(2'd1, 32'h10);
    reg_rd(2'd1, st);
    chk(st[5:4] == 2'b10 && irq_err && !irq_done, "R8 clear done only", st, 32'h23);
    reg_wr(2'd1, 32'h0);
    reg_rd(2'd1, st);
    chk(st[5:4] == 2'b10, "R8 zero write no effect", st, 32'h23);
    reg_wr(2'd1, 32'h20);
    reg_rd(2'd1, st);
    chk(st == 32'h3, "R8 clear error irq", st, 32'h3);
    reg_wr(2'd0, 32'd0);
    reg_wr(2'd0, 32'd1);
    reg_rd(2'd1, st);
    chk(st == 32'h0, "R7 run cycle clears", st, 32'h0);
    reg_wr(2'd3, 32'd8);
    #1 chk(s_tready, "R7 restart after run cycle", {31'b0, s_tready}, 32'd1);

    finish_run();
  end
endmodule